// File: doc/BRIEF.md
# Packet Interrupt Delay Timer

This block produces the interrupts of one streaming DMA channel. It combines two ways of coalescing them. The first is a count of finished packets: a completion interrupt is raised once the count reaches a programmable threshold. The second is a delay timer for the packets left over when traffic stops. The delay timer starts when a packet ends and stops as soon as a new packet begins. If no packet follows within the programmed number of timeout intervals, it raises a delay interrupt. A trailing packet therefore never waits for the threshold.

Each timeout interval is a fixed 125 block clocks, produced by an internal prescaler. The delay setting counts these intervals. Both interrupts are sticky levels. Software drops them by pulsing the clear input.

Top module: `pkt_irq_delay`

## Requirements
- R1: While synchronous active-high reset is asserted, and in the first cycle after it, both interrupt outputs are low. The reset also clears the packet count, the interval counter and the prescaler.
- R2: After a single-cycle end-of-packet strobe, with a delay setting D from 1 to 255 and no later strobe, the delay interrupt rises exactly 125*D clock edges after the edge that sampled the strobe. It is still low one edge earlier.
- R3: A delay setting of 0 never raises the delay interrupt.
- R4: A start-of-packet strobe cancels a running timer, and no delay interrupt follows.
- R5: When end-of-packet and start-of-packet strobes are sampled in the same cycle, the end is handled first and the start second, so the timer is left cancelled.
- R6: Both interrupts stay high until a cycle with the clear input high. If a delay timeout and the clear fall in the same cycle, the delay interrupt stays high.
- R7: With a threshold T from 1 to 255, the completion interrupt rises on the edge that samples the T-th end of packet counted since reset or since the last completion. That edge also zeroes the count and cancels the delay timer. A threshold of 0 disables the completion interrupt.
- R8: A change to the delay setting while the timer runs is applied at the next interval boundary. If the intervals already counted reach or exceed the new setting, the timeout happens on that boundary.
- R9: An end-of-packet strobe during a running timer restarts it, with a full 125-clock first interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| eop_i | input | 1 | End-of-packet strobe, one cycle per packet |
| sop_i | input | 1 | Start-of-packet strobe |
| delay_cfg_i | input | 8 | Delay in timeout intervals, 0 = off |
| coal_thresh_i | input | 8 | Packets per completion interrupt, 0 = off |
| irq_clr_i | input | 1 | Clears both interrupt flags |
| dly_irq_o | output | 1 | Sticky delay-timeout interrupt |
| cmp_irq_o | output | 1 | Sticky completion interrupt |

## Verification
The bound checker watches, on every cycle, that both flags are held until cleared and that reset leaves them low. It also checks that a zero delay, a start of packet, or a simultaneous start and end never produce a delay-interrupt edge, and that a completion edge always follows a sampled end of packet. The exact distance of 125*D edges depends on the prescaler and the interval count together, so only the bench scenarios can show it. The same holds for the restart on a second end of packet, the early timeout after the setting is lowered, and the zeroing of the packet count after a completion.

// File: rtl/pid_pkg.sv
package pid_pkg;
  localparam int unsigned PID_DLY_W   = 8;
  localparam int unsigned PID_CNT_W   = 8;
  localparam int unsigned PID_PRESCALE = 125;
  localparam int unsigned PID_NUM_IRQ = 2;

  typedef enum logic [0:0] {
    IRQ_DELAY = 1'b0,
    IRQ_CMPL  = 1'b1
  } irq_idx_e;

  typedef struct packed {
    logic arm;
    logic cancel;
    logic restart;
  } tmr_ctl_t;
endpackage

// File: rtl/pid_prescaler.sv
module pid_prescaler #(
  parameter int unsigned DIV = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q;

  assign tick = run && !restart && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart || !run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pid_delay_timer.sv
module pid_delay_timer
  import pid_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  tmr_ctl_t      ctl,
  input  logic          tick,
  input  logic [DW-1:0] delay,
  output logic          running,
  output logic          fire
);
  logic [DW-1:0] ivl_q;
  logic [DW:0]   ivl_inc;
  logic          dly_off;

  assign dly_off = (delay == '0);
  assign ivl_inc = {1'b0, ivl_q} + 1'b1;
  assign fire = running && tick && !ctl.arm && !ctl.cancel && !dly_off &&
                (ivl_inc >= {1'b0, delay});

  always_ff @(posedge clk) begin
    if (rst || ctl.cancel) begin
      running <= 1'b0;
      ivl_q   <= '0;
    end else if (ctl.arm) begin
      running <= !dly_off;
      ivl_q   <= '0;
    end else if (!running || dly_off || fire) begin
      running <= 1'b0;
      ivl_q   <= '0;
    end else if (tick) begin
      ivl_q <= ivl_inc[DW-1:0];
    end
  end
endmodule

// File: rtl/pid_pkt_coalescer.sv
module pid_pkt_coalescer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          eop,
  input  logic [CW-1:0] thresh,
  output logic          hit
);
  logic [CW-1:0] pkt_q;
  logic [CW:0]   pkt_inc;

  assign pkt_inc = {1'b0, pkt_q} + 1'b1;
  assign hit = eop && (thresh != '0) && (pkt_inc >= {1'b0, thresh});

  always_ff @(posedge clk) begin
    if (rst || hit) begin
      pkt_q <= '0;
    end else if (eop && !pkt_inc[CW]) begin
      pkt_q <= pkt_inc[CW-1:0];
    end
  end
endmodule

// File: rtl/pid_sticky_flag.sv
module pid_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (set) begin
      flag <= 1'b1;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/pkt_irq_delay.sv
module pkt_irq_delay
  import pid_pkg::*;
#(
  parameter int unsigned DLY_W    = PID_DLY_W,
  parameter int unsigned CNT_W    = PID_CNT_W,
  parameter int unsigned PRESCALE = PID_PRESCALE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eop_i,
  input  logic             sop_i,
  input  logic [DLY_W-1:0] delay_cfg_i,
  input  logic [CNT_W-1:0] coal_thresh_i,
  input  logic             irq_clr_i,
  output logic             dly_irq_o,
  output logic             cmp_irq_o
);
  tmr_ctl_t               ctl;
  logic                   tick;
  logic                   running;
  logic                   fire;
  logic                   cmp_hit;
  logic [PID_NUM_IRQ-1:0] irq_set;
  logic [PID_NUM_IRQ-1:0] irq_q;

  // end of packet first, then start of packet / completion cancel
  assign ctl.arm     = eop_i;
  assign ctl.cancel  = sop_i || cmp_hit;
  assign ctl.restart = eop_i || sop_i || cmp_hit;

  pid_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (running),
    .restart (ctl.restart),
    .tick    (tick)
  );

  pid_delay_timer #(.DW(DLY_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .tick    (tick),
    .delay   (delay_cfg_i),
    .running (running),
    .fire    (fire)
  );

  pid_pkt_coalescer #(.CW(CNT_W)) u_coal (
    .clk    (clk),
    .rst    (rst),
    .eop    (eop_i),
    .thresh (coal_thresh_i),
    .hit    (cmp_hit)
  );

  assign irq_set[IRQ_DELAY] = fire;
  assign irq_set[IRQ_CMPL]  = cmp_hit;

  for (genvar g = 0; g < PID_NUM_IRQ; g++) begin : g_flag
    pid_sticky_flag u_flag (
      .clk  (clk),
      .rst  (rst),
      .set  (irq_set[g]),
      .clr  (irq_clr_i),
      .flag (irq_q[g])
    );
  end

  assign dly_irq_o = irq_q[IRQ_DELAY];
  assign cmp_irq_o = irq_q[IRQ_CMPL];
endmodule

// File: rtl/pkt_irq_delay_chk.sv
module pkt_irq_delay_chk #(
  parameter int unsigned DLY_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             eop_i,
  input logic             sop_i,
  input logic [DLY_W-1:0] delay_cfg_i,
  input logic             irq_clr_i,
  input logic             dly_irq_o,
  input logic             cmp_irq_o
);
  p_rst_clear_r1: assert property (@(posedge clk)
    rst |=> (!dly_irq_o && !cmp_irq_o));

  p_zero_delay_r3: assert property (@(posedge clk) disable iff (rst)
    (delay_cfg_i == '0) |=> !$rose(dly_irq_o));

  p_sop_cancel_r4: assert property (@(posedge clk) disable iff (rst)
    sop_i |=> !$rose(dly_irq_o));

  p_same_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    (eop_i && sop_i) |=> !$rose(dly_irq_o));

  p_dly_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (dly_irq_o && !irq_clr_i) |=> dly_irq_o);

  p_cmp_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (cmp_irq_o && !irq_clr_i) |=> cmp_irq_o);

  p_cmp_after_eop_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(cmp_irq_o) |-> $past(eop_i));
endmodule

bind pkt_irq_delay pkt_irq_delay_chk #(.DLY_W(DLY_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .eop_i       (eop_i),
  .sop_i       (sop_i),
  .delay_cfg_i (delay_cfg_i),
  .irq_clr_i   (irq_clr_i),
  .dly_irq_o   (dly_irq_o),
  .cmp_irq_o   (cmp_irq_o)
);

// File: tb/pkt_irq_delay_tb_top.sv
module pkt_irq_delay_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IVL = 125;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       eop = 1'b0;
  logic       sop = 1'b0;
  logic [7:0] dly = 8'd0;
  logic [7:0] thr = 8'd0;
  logic       clr = 1'b0;
  logic       dly_irq;
  logic       cmp_irq;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [7:0]  delay;
    logic [15:0] wait_n;
    logic        exp;
  } vec_t;

  // delay setting, edges waited after the end-of-packet edge, expected delay irq
  localparam vec_t VEC [8] = '{
    '{8'd1,   16'd124,  1'b0},
    '{8'd1,   16'd125,  1'b1},
    '{8'd2,   16'd249,  1'b0},
    '{8'd2,   16'd250,  1'b1},
    '{8'd7,   16'd874,  1'b0},
    '{8'd7,   16'd875,  1'b1},
    '{8'd0,   16'd600,  1'b0},
    '{8'd255, 16'd1000, 1'b0}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_irq_delay dut_i (
    .clk           (clk),
    .rst           (rst),
    .eop_i         (eop),
    .sop_i         (sop),
    .delay_cfg_i   (dly),
    .coal_thresh_i (thr),
    .irq_clr_i     (clr),
    .dly_irq_o     (dly_irq),
    .cmp_irq_o     (cmp_irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    edges(2);
    rst = 1'b0;
  endtask

  task automatic pulse_eop();
    eop = 1'b1;
    edges(1);
    eop = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 dly after reset", dly_irq, 1'b0);
    chk("R1 cmp after reset", cmp_irq, 1'b0);

    // R2 / R3 vector walk
    foreach (VEC[i]) begin
      do_reset();
      dly = VEC[i].delay;
      pulse_eop();
      edges(int'(VEC[i].wait_n));
      chk(VEC[i].delay == 0 ? "R3 zero delay" : "R2 timeout distance",
          dly_irq, VEC[i].exp);
    end

    // R4 start of packet cancels
    do_reset();
    dly = 8'd1;
    pulse_eop();
    edges(60);
    sop = 1'b1; edges(1); sop = 1'b0;
    edges(300);
    chk("R4 sop cancel", dly_irq, 1'b0);

    // R5 same-cycle eop and sop
    do_reset();
    eop = 1'b1; sop = 1'b1; edges(1); eop = 1'b0; sop = 1'b0;
    edges(300);
    chk("R5 eop+sop cancelled", dly_irq, 1'b0);

    // R6 sticky flag, clear, set wins over clear
    do_reset();
    pulse_eop();
    edges(125);
    chk("R6 set", dly_irq, 1'b1);
    edges(50);
    chk("R6 held", dly_irq, 1'b1);
    clr = 1'b1; edges(1); clr = 1'b0;
    chk("R6 cleared", dly_irq, 1'b0);
    pulse_eop();
    edges(124);
    chk("R6 before timeout", dly_irq, 1'b0);
    clr = 1'b1; edges(1); clr = 1'b0;
    chk("R6 set beats clear", dly_irq, 1'b1);

    // R9 re-arm restarts full interval
    do_reset();
    pulse_eop();
    edges(100);
    pulse_eop();
    edges(124);
    chk("R9 restart not yet", dly_irq, 1'b0);
    edges(1);
    chk("R9 restart timeout", dly_irq, 1'b1);

    // R8 lowering the delay while running
    do_reset();
    dly = 8'd5;
    pulse_eop();
    edges(3 * IVL);
    dly = 8'd2;
    edges(IVL - 1);
    chk("R8 before boundary", dly_irq, 1'b0);
    edges(1);
    chk("R8 fires at boundary", dly_irq, 1'b1);

    // R7 coalescing threshold
    do_reset();
    dly = 8'd1;
    thr = 8'd3;
    pulse_eop();
    pulse_eop();
    chk("R7 below threshold", cmp_irq, 1'b0);
    pulse_eop();
    chk("R7 threshold reached", cmp_irq, 1'b1);
    edges(300);
    chk("R7 timer cancelled", dly_irq, 1'b0);
    clr = 1'b1; edges(1); clr = 1'b0;
    chk("R7 cleared", cmp_irq, 1'b0);
    pulse_eop();
    pulse_eop();
    chk("R7 count restarted", cmp_irq, 1'b0);
    pulse_eop();
    chk("R7 second completion", cmp_irq, 1'b1);

    // R7 threshold zero disables
    do_reset();
    thr = 8'd0;
    dly = 8'd0;
    repeat (10) pulse_eop();
    chk("R7 threshold zero", cmp_irq, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule